// File: doc/BRIEF.md
# Interval Counter Channel

A single 16-bit down-counting timer channel for a chip-level timer block. It runs from a fast system clock and watches a slower timer-clock input. The count is loaded or stepped only when that timer clock falls. A gate input, a mode selector and a binary/BCD selector decide how the count moves and how the single output pin behaves. Six behaviours are available: interrupt on terminal count, gate-retriggerable one-shot, rate generator, square wave, software-triggered strobe and gate-triggered strobe.

Software-side logic (bus decode, byte sequencing, read-back) lives elsewhere. It hands this channel a full reload value with a strobe, and a mode selection with a "command written" strobe. The live count is exposed on a port so that a neighbouring latch can capture it.

Encodings: mode 0 is terminal-count interrupt, 1 is one-shot, 2 is rate generator, 3 is square wave, 4 is software strobe and 5 is gate strobe. Codes 6 and 7 alias modes 2 and 3. A BCD select of 1 treats the count as four decimal digits.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the output pin is low and the count is 0.
- R2: One system clock after a command strobe, the output is low for mode 0 and high for modes 1 to 5, and the count holds its old value until a reload value is loaded. Mode codes 6 and 7 behave as modes 2 and 3.
- R3: The count changes only in the system clock cycle that sees the timer clock go from high to low. A rising timer-clock edge never changes it. The falling edge that copies the reload value into the count does not also decrement it.
- R4: In mode 0 the output goes high when the count steps from 1 to 0. It stays high while the count wraps on (0 to 0xFFFF). A reload write drives it low again.
- R5: In modes 1 and 5 the count loads only on the falling edge after a gate rising edge, and only if that rising edge came after a reload write. The gate level is ignored while counting. A new gate rising edge reloads the count. In mode 1 the output is low from the load until the count steps from 1 to 0.
- R6: In mode 2 the output goes low when the count steps from 2 to 1. On the next counting falling edge it returns high and the count reloads.
- R7: In modes 2 and 3, gate low forces the output high one system clock later and stops counting. After the gate rises, the next falling edge reloads the count.
- R8: In mode 3 with an even reload N, the count loads N, steps by 2, and the output toggles with a reload when the count is 2. Each output level lasts N/2 falling edges.
- R9: In mode 3 with an odd reload N, the count loads N-1. The high phase lasts (N+1)/2 falling edges, with the count passing through 0. The low phase lasts (N-1)/2.
- R10: In modes 4 and 5 the output goes low when the count steps from 1 to 0 and returns high on the next falling edge. In mode 4, gate low pauses the count without a reload and without touching the output.
- R11: In modes 0 and 4 a reload write is loaded on the next falling edge. In modes 1, 2, 3 and 5, after the first load, a new reload value waits for the next natural reload or gate retrigger.
- R12: With BCD select set, the count decrements with a decimal borrow per digit (0010 to 0009) and wraps from 0000 to 9999. A reload of 0 gives the maximum period in both binary and BCD (0 to 0xFFFF, or 0 to 9999, on the first step).
- R13: In modes 0, 2, 3 and 4 a falling edge decrements only if the gate was high at the preceding rising timer-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrClkIn | input | 1 | Timer clock, synchronous to clk, much slower than clk |
| gateIn | input | 1 | Gate input |
| modeSel | input | 3 | Mode code, captured on cmdWr |
| bcdSel | input | 1 | 1 selects BCD counting, captured on cmdWr |
| cmdWr | input | 1 | Command written strobe, one clk wide |
| reloadVal | input | WIDTH | Full reload value |
| reloadWr | input | 1 | Reload written strobe, one clk wide |
| outPin | output | 1 | Channel output |
| countOut | output | WIDTH | Current count |

## Verification
The count and the output change on the system clock edge that first samples the timer clock low after it was high. The bench drives every input on a falling system clock edge and completes each timer-clock fall one system clock before it samples, so each check falls exactly one register stage after its stimulus. The level forced by a command and the output forced high by gate low are both due one system clock later, and are checked at the next falling system clock edge. A gate rising edge is given one full system clock to register before the next timer-clock rise, so the loads that depend on it land on the following fall.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [2:0] {
    TM_TERM    = 3'd0,
    TM_ONESHOT = 3'd1,
    TM_RATE    = 3'd2,
    TM_SQUARE  = 3'd3,
    TM_SOFTSTB = 3'd4,
    TM_GATESTB = 3'd5
  } tmMode_e;

  // Strobes from the control to the count datapath
  typedef struct packed {
    logic latch;    // capture a new reload value
    logic load;     // copy reload into count
    logic dec;      // step the count down
    logic twoStep;  // square-wave: step by two, load even value
  } cntCtl_t;

endpackage

// File: rtl/itc_edges.sv
module itc_edges (
  input  logic clk,
  input  logic rstN,
  input  logic tmrClkIn,
  input  logic gateIn,
  output logic tFall,
  output logic gateLvl,
  output logic gateRise
);
  logic tPrev;
  logic gPrev;
  logic tRise;

  assign tFall    = tPrev & ~tmrClkIn;
  assign tRise    = ~tPrev & tmrClkIn;
  assign gateRise = gateIn & ~gPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tPrev   <= 1'b0;
      gPrev   <= 1'b0;
      gateLvl <= 1'b0;
    end else begin
      tPrev <= tmrClkIn;
      gPrev <= gateIn;
      if (tRise) gateLvl <= gateIn;  // gate level seen at the timer rising edge
    end
  end
endmodule

// File: rtl/itc_count.sv
module itc_count
  import itc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctl,
  input  logic             bcdMode,
  input  logic [WIDTH-1:0] reloadVal,
  output logic [WIDTH-1:0] countQ,
  output logic             cntZero,
  output logic             cntOne,
  output logic             cntTwo,
  output logic             reloadOdd
);
  localparam int DIGITS = WIDTH / 4;
  localparam logic [WIDTH-1:0] BCD_TOP = WIDTH'({DIGITS{4'h9}});

  function automatic logic [WIDTH-1:0] bcdDecOne(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (v[d*4 +: 4] == 4'd0) begin
          r[d*4 +: 4] = 4'd9;
        end else begin
          r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  logic [WIDTH-1:0] reloadQ;
  logic [WIDTH-1:0] cntQ;
  logic [WIDTH-1:0] loadVal;
  logic [WIDTH-1:0] decOnce;
  logic [WIDTH-1:0] decVal;

  assign loadVal = ctl.twoStep ? {reloadQ[WIDTH-1:1], 1'b0} : reloadQ;
  assign decOnce = bcdMode ? bcdDecOne(cntQ) : cntQ - WIDTH'(1);
  assign decVal  = !ctl.twoStep ? decOnce
                 : (bcdMode ? bcdDecOne(decOnce) : cntQ - WIDTH'(2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
      cntQ    <= '0;
    end else begin
      if (ctl.latch) reloadQ <= reloadVal;
      if (ctl.load)      cntQ <= loadVal;
      else if (ctl.dec)  cntQ <= decVal;
    end
  end

  assign countQ    = cntQ;
  assign cntZero   = (cntQ == '0);
  assign cntOne    = (cntQ == WIDTH'(1));
  assign cntTwo    = (cntQ == WIDTH'(2));
  assign reloadOdd = reloadQ[0];

  // R12: a single BCD step from 0000 wraps to all-nines
  p_bcd_wrap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dec && !ctl.load && !ctl.twoStep && bcdMode && cntQ == '0) |=> (cntQ == BCD_TOP));

  // R12: a single binary step from 0 wraps to all-ones
  p_bin_wrap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dec && !ctl.load && !ctl.twoStep && !bcdMode && cntQ == '0) |=> (cntQ == '1));
endmodule

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tFall,
  input  logic       gateLvl,
  input  logic       gateRise,
  input  logic       gateIn,
  input  logic [2:0] modeSel,
  input  logic       bcdSel,
  input  logic       cmdWr,
  input  logic       reloadWr,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       cntTwo,
  input  logic       reloadOdd,
  output cntCtl_t    ctl,
  output logic       bcdMode,
  output logic       outPin
);
  tmMode_e modeQ;
  tmMode_e modeEff;
  logic    bcdQ;
  logic    outQ;
  logic    outNext;
  logic    armed;
  logic    loadReq;
  logic    trigPend;
  logic    running;
  logic    gatedMode;
  logic    stepOk;
  logic    waveMode;
  logic    trigMode;

  // codes 6 and 7 fold onto rate generator and square wave
  assign modeEff   = tmMode_e'(modeSel[1] ? {1'b0, modeSel[1:0]} : modeSel);
  assign gatedMode = (modeQ inside {TM_TERM, TM_RATE, TM_SQUARE, TM_SOFTSTB});
  assign waveMode  = (modeQ inside {TM_RATE, TM_SQUARE});
  assign trigMode  = (modeQ inside {TM_ONESHOT, TM_GATESTB});
  assign stepOk    = running && (gateLvl || !gatedMode);

  always_comb begin
    ctl         = '0;
    ctl.latch   = reloadWr && !cmdWr;
    ctl.twoStep = (modeQ == TM_SQUARE);
    outNext     = outQ;
    if (tFall && !cmdWr) begin
      unique case (modeQ)
        TM_TERM: begin
          if (loadReq) ctl.load = 1'b1;
          else if (stepOk) begin
            ctl.dec = 1'b1;
            if (cntOne) outNext = 1'b1;
          end
        end
        TM_ONESHOT: begin
          if (trigPend) begin
            ctl.load = 1'b1;
            outNext  = 1'b0;
          end else if (stepOk) begin
            ctl.dec = 1'b1;
            if (cntOne) outNext = 1'b1;
          end
        end
        TM_RATE: begin
          if (loadReq) begin
            ctl.load = 1'b1;
            outNext  = 1'b1;
          end else if (stepOk) begin
            if (cntOne) begin
              ctl.load = 1'b1;
              outNext  = 1'b1;
            end else begin
              ctl.dec = 1'b1;
              if (cntTwo) outNext = 1'b0;
            end
          end
        end
        TM_SQUARE: begin
          if (loadReq) begin
            ctl.load = 1'b1;
            outNext  = 1'b1;
          end else if (stepOk) begin
            if (reloadOdd && outQ && cntTwo) begin
              ctl.dec = 1'b1;          // odd reload: stretch the high phase
            end else if (cntTwo || (reloadOdd && outQ && cntZero)) begin
              ctl.load = 1'b1;
              outNext  = !outQ;
            end else begin
              ctl.dec = 1'b1;
            end
          end
        end
        TM_SOFTSTB, TM_GATESTB: begin
          if (!outQ) outNext = 1'b1;   // strobe lasts one timer cycle
          if ((modeQ == TM_SOFTSTB) ? loadReq : trigPend) ctl.load = 1'b1;
          else if (stepOk) begin
            ctl.dec = 1'b1;
            if (cntOne) outNext = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= TM_TERM;
      bcdQ     <= 1'b0;
      outQ     <= 1'b0;
      armed    <= 1'b0;
      loadReq  <= 1'b0;
      trigPend <= 1'b0;
      running  <= 1'b0;
    end else if (cmdWr) begin
      modeQ    <= modeEff;
      bcdQ     <= bcdSel;
      outQ     <= (modeEff != TM_TERM);
      armed    <= 1'b0;
      loadReq  <= 1'b0;
      trigPend <= 1'b0;
      running  <= 1'b0;
    end else begin
      outQ <= outNext;
      if (ctl.load) begin
        loadReq  <= 1'b0;
        trigPend <= 1'b0;
        running  <= 1'b1;
      end
      if (reloadWr) begin
        armed <= 1'b1;
        unique case (modeQ)
          TM_TERM: begin
            loadReq <= 1'b1;
            outQ    <= 1'b0;
          end
          TM_SOFTSTB:          loadReq <= 1'b1;
          TM_RATE, TM_SQUARE:  if (!armed) loadReq <= 1'b1;
          default: ;
        endcase
      end
      if (gateRise && armed) begin
        if (trigMode)      trigPend <= 1'b1;
        else if (waveMode) loadReq  <= 1'b1;
      end
      if (waveMode && !gateIn) outQ <= 1'b1;
    end
  end

  assign outPin  = outQ;
  assign bcdMode = bcdQ;

  // R3: count strobes only on a timer falling edge, never load and step together
  p_strobe_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load || ctl.dec) |-> tFall);
  p_load_excl_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.dec));

  // R2: command forces the mode's initial output level
  p_cmd_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> (outQ == ($past(modeEff) != TM_TERM)));

  // R4: terminal count raises and then holds the output in mode 0
  p_term_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == TM_TERM && ctl.dec && cntOne && !cmdWr && !reloadWr) |=> outQ);
  p_term_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == TM_TERM && outQ && !cmdWr && !reloadWr) |=> outQ);

  // R5: the one-shot output is low right after its load
  p_oneshot_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == TM_ONESHOT && ctl.load && !cmdWr) |=> !outQ);

  // R6: rate generator is only low while the count sits at one
  p_rate_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == TM_RATE && !outQ) |-> cntOne);

  // R7: gate low forces the output high in the wave modes
  p_gate_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode && !gateIn && !cmdWr) |=> outQ);

  // R10: a strobe pulse ends at the next timer falling edge
  p_strobe_short_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ inside {TM_SOFTSTB, TM_GATESTB}) && !outQ && tFall && !cmdWr) |=> outQ);

  // R13: gated modes step only with the gate seen high at the rising edge
  p_gated_step_r13: assert property (@(posedge clk) disable iff (!rstN)
    (gatedMode && ctl.dec) |-> gateLvl);
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tmrClkIn,
  input  logic             gateIn,
  input  logic [2:0]       modeSel,
  input  logic             bcdSel,
  input  logic             cmdWr,
  input  logic [WIDTH-1:0] reloadVal,
  input  logic             reloadWr,
  output logic             outPin,
  output logic [WIDTH-1:0] countOut
);
  logic    tFall;
  logic    gateLvl;
  logic    gateRise;
  cntCtl_t ctl;
  logic    bcdMode;
  logic    cntZero;
  logic    cntOne;
  logic    cntTwo;
  logic    reloadOdd;

  itc_edges u_edges (
    .clk      (clk),
    .rstN     (rstN),
    .tmrClkIn (tmrClkIn),
    .gateIn   (gateIn),
    .tFall    (tFall),
    .gateLvl  (gateLvl),
    .gateRise (gateRise)
  );

  itc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tFall     (tFall),
    .gateLvl   (gateLvl),
    .gateRise  (gateRise),
    .gateIn    (gateIn),
    .modeSel   (modeSel),
    .bcdSel    (bcdSel),
    .cmdWr     (cmdWr),
    .reloadWr  (reloadWr),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .cntTwo    (cntTwo),
    .reloadOdd (reloadOdd),
    .ctl       (ctl),
    .bcdMode   (bcdMode),
    .outPin    (outPin)
  );

  itc_count #(.WIDTH(WIDTH)) u_count (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .bcdMode   (bcdMode),
    .reloadVal (reloadVal),
    .countQ    (countOut),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .cntTwo    (cntTwo),
    .reloadOdd (reloadOdd)
  );
endmodule

// File: tb/sim_interval_timer_chan.sv
module sim_interval_timer_chan;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tmr = 1'b0;
  logic        gate = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic        bcdSel = 1'b0;
  logic        cmdWr = 1'b0;
  logic [15:0] reloadVal = 16'd0;
  logic        reloadWr = 1'b0;
  logic        outPin;
  logic [15:0] countOut;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_timer_chan u0 (
    .clk(clk), .rstN(rstN), .tmrClkIn(tmr), .gateIn(gate),
    .modeSel(modeSel), .bcdSel(bcdSel), .cmdWr(cmdWr),
    .reloadVal(reloadVal), .reloadWr(reloadWr),
    .outPin(outPin), .countOut(countOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // count and output together
  task automatic chkCO(input string tag, input logic [15:0] c, input logic o);
    chk({tag, " count"}, countOut, c);
    chk({tag, " out"}, {15'd0, outPin}, {15'd0, o});
  endtask

  task automatic tfall();
    @(negedge clk) tmr = 1'b1;
    @(negedge clk);
    @(negedge clk) tmr = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] m, input logic b);
    @(negedge clk) begin modeSel = m; bcdSel = b; cmdWr = 1'b1; end
    @(negedge clk) cmdWr = 1'b0;
  endtask

  task automatic reload(input logic [15:0] v);
    @(negedge clk) begin reloadVal = v; reloadWr = 1'b1; end
    @(negedge clk) reloadWr = 1'b0;
  endtask

  task automatic setGate(input logic g);
    @(negedge clk) gate = g;
    @(negedge clk);
  endtask

  task automatic testReset();
    chkCO("R1 reset", 16'h0000, 1'b0);
  endtask

  task automatic testTerm();
    setGate(1'b1);
    cmd(3'd0, 1'b0);
    chk("R2 mode0 initial low", {15'd0, outPin}, 16'd0);
    reload(16'd3);
    chk("R11 mode0 not loaded before fall", countOut, 16'd0);
    @(negedge clk) tmr = 1'b1;
    @(negedge clk);
    chk("R3 rising edge leaves count", countOut, 16'd0);
    @(negedge clk) tmr = 1'b0;
    @(negedge clk);
    chkCO("R3 load without step", 16'd3, 1'b0);
    tfall(); chkCO("R3 first step", 16'd2, 1'b0);
    tfall(); chkCO("R4 before terminal", 16'd1, 1'b0);
    tfall(); chkCO("R4 terminal high", 16'd0, 1'b1);
    tfall(); chkCO("R4 wrap keeps high", 16'hFFFF, 1'b1);
    reload(16'd5);
    chk("R4 reload drives low", {15'd0, outPin}, 16'd0);
    tfall(); chk("R11 mode0 loads next fall", countOut, 16'd5);
  endtask

  task automatic testGateSample();
    setGate(1'b0);
    tfall(); chk("R13 gate low no step", countOut, 16'd5);
    @(negedge clk) tmr = 1'b1;
    @(negedge clk) gate = 1'b1;
    @(negedge clk) tmr = 1'b0;
    @(negedge clk);
    chk("R13 gate raised after rising edge", countOut, 16'd5);
    tfall(); chk("R13 gate high steps", countOut, 16'd4);
  endtask

  task automatic testOneShot();
    logic [15:0] held;
    cmd(3'd1, 1'b0);
    chk("R2 mode1 initial high", {15'd0, outPin}, 16'd1);
    setGate(1'b0);
    held = countOut;
    setGate(1'b1);
    setGate(1'b0);
    reload(16'd3);
    tfall(); chkCO("R5 no trigger no load", held, 1'b1);
    setGate(1'b1);
    tfall(); chkCO("R5 trigger loads low", 16'd3, 1'b0);
    setGate(1'b0);
    tfall(); chkCO("R5 gate low ignored", 16'd2, 1'b0);
    tfall(); chkCO("R5 counting low", 16'd1, 1'b0);
    tfall(); chkCO("R5 terminal high", 16'd0, 1'b1);
    setGate(1'b1);
    tfall(); chkCO("R5 retrigger reloads", 16'd3, 1'b0);
  endtask

  task automatic testGateStrobe();
    cmd(3'd5, 1'b0);
    setGate(1'b0);
    reload(16'd2);
    setGate(1'b1);
    tfall(); chkCO("R5 mode5 load keeps high", 16'd2, 1'b1);
    tfall(); chkCO("R10 mode5 step", 16'd1, 1'b1);
    tfall(); chkCO("R10 mode5 pulse low", 16'd0, 1'b0);
    tfall(); chkCO("R10 mode5 pulse ends", 16'hFFFF, 1'b1);
  endtask

  task automatic testSoftStrobe();
    cmd(3'd4, 1'b0);
    reload(16'd3);
    tfall(); chkCO("R10 mode4 load", 16'd3, 1'b1);
    tfall(); chk("R10 mode4 step", countOut, 16'd2);
    setGate(1'b0);
    tfall(); chkCO("R10 mode4 gate pause", 16'd2, 1'b1);
    setGate(1'b1);
    tfall(); chk("R10 mode4 resumes", countOut, 16'd1);
    tfall(); chkCO("R10 mode4 pulse low", 16'd0, 1'b0);
    tfall(); chkCO("R10 mode4 pulse ends", 16'hFFFF, 1'b1);
    reload(16'd7);
    tfall(); chk("R11 mode4 loads next fall", countOut, 16'd7);
  endtask

  task automatic testRate();
    cmd(3'd2, 1'b0);
    reload(16'd3);
    tfall(); chkCO("R6 load", 16'd3, 1'b1);
    tfall(); chkCO("R6 step", 16'd2, 1'b1);
    tfall(); chkCO("R6 low at one", 16'd1, 1'b0);
    tfall(); chkCO("R6 reload high", 16'd3, 1'b1);
    reload(16'd5);
    tfall(); chk("R11 mode2 keeps old period", countOut, 16'd2);
    tfall(); chkCO("R11 mode2 low", 16'd1, 1'b0);
    tfall(); chkCO("R11 mode2 new value at reload", 16'd5, 1'b1);
    tfall(); tfall(); tfall(); tfall();
    chkCO("R6 low before gate drop", 16'd1, 1'b0);
    setGate(1'b0);
    chk("R7 gate low forces high", {15'd0, outPin}, 16'd1);
    tfall(); chk("R7 gate low stops count", countOut, 16'd1);
    setGate(1'b1);
    tfall(); chkCO("R7 gate return reloads", 16'd5, 1'b1);
  endtask

  task automatic testSquareEven();
    cmd(3'd3, 1'b0);
    reload(16'd6);
    tfall(); chkCO("R8 load", 16'd6, 1'b1);
    tfall(); chkCO("R8 step two", 16'd4, 1'b1);
    tfall(); chkCO("R8 step two again", 16'd2, 1'b1);
    tfall(); chkCO("R8 toggle low", 16'd6, 1'b0);
    tfall(); chkCO("R8 low step", 16'd4, 1'b0);
    tfall(); chkCO("R8 low last", 16'd2, 1'b0);
    tfall(); chkCO("R8 toggle high", 16'd6, 1'b1);
  endtask

  task automatic testSquareOdd();
    cmd(3'd3, 1'b0);
    reload(16'd5);
    tfall(); chkCO("R9 odd loads N-1", 16'd4, 1'b1);
    tfall(); chkCO("R9 step", 16'd2, 1'b1);
    tfall(); chkCO("R9 high stretched", 16'd0, 1'b1);
    tfall(); chkCO("R9 toggle low", 16'd4, 1'b0);
    tfall(); chkCO("R9 low step", 16'd2, 1'b0);
    tfall(); chkCO("R9 toggle high", 16'd4, 1'b1);
    tfall(); tfall(); tfall();
    chkCO("R9 second low", 16'd4, 1'b0);
    setGate(1'b0);
    chk("R7 mode3 gate low forces high", {15'd0, outPin}, 16'd1);
    setGate(1'b1);
    tfall(); chkCO("R7 mode3 gate return reloads", 16'd4, 1'b1);
  endtask

  task automatic testAlias();
    cmd(3'd6, 1'b0);
    chk("R2 code6 initial high", {15'd0, outPin}, 16'd1);
    reload(16'd3);
    tfall(); tfall(); tfall();
    chkCO("R2 code6 acts as rate", 16'd1, 1'b0);
    cmd(3'd7, 1'b0);
    reload(16'd4);
    tfall(); tfall();
    chk("R2 code7 acts as square", countOut, 16'd2);
  endtask

  task automatic testBcd();
    cmd(3'd0, 1'b1);
    reload(16'h0010);
    tfall(); chk("R12 bcd load", countOut, 16'h0010);
    tfall(); chk("R12 bcd borrow", countOut, 16'h0009);
    tfall(); chk("R12 bcd step", countOut, 16'h0008);
    reload(16'h0000);
    tfall(); chk("R12 bcd zero load", countOut, 16'h0000);
    tfall(); chk("R12 bcd wrap 9999", countOut, 16'h9999);
    cmd(3'd3, 1'b1);
    reload(16'h0100);
    tfall(); tfall();
    chk("R12 bcd square steps two", countOut, 16'h0098);
    cmd(3'd0, 1'b0);
    reload(16'h0000);
    tfall(); tfall();
    chk("R12 binary zero reload max", countOut, 16'hFFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTerm();
    testGateSample();
    testOneShot();
    testGateStrobe();
    testSoftStrobe();
    testRate();
    testSquareEven();
    testSquareOdd();
    testAlias();
    testBcd();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule